// File: doc/BRIEF.md
# Palette Lookup DAC Host Register File

This block is the host-facing register file and lookup path of a colour-lookup DAC. A host reaches it through a byte-wide bus with a two-bit port select. One port holds an entry pointer. A second port streams colour components into a 256-entry colour map, or out of it, three bytes per entry. A third port reaches a small bank of control registers selected through the same pointer. A fourth port, reserved for an overlay map, is accepted and ignored.

On the video side, an 8-bit pixel index is masked by the pixel read mask and used to look up a 24-bit colour. The colour leaves as separate 8-bit red, green and blue bytes, one cycle after the index. A colour-map load stages red and green and commits the whole entry on the blue byte. The pointer then advances, so a run of consecutive entries needs only one pointer write. Control-register writes never move the pointer.

Top module: `palette_dac_regs`

## Requirements
- R1: After reset the pointer is 0x00, the read mask is 0xFF, and the blink, command and test registers are 0x00. `busRdata`, `pixR`, `pixG` and `pixB` read 0.
- R2: A write to port 0 (`busSel`=0) loads the pointer and returns both the write and the read component sequences to red. A read of port 0 returns the pointer.
- R3: Writes to port 1 take red, green and blue in that order. The entry at the pointer is updated only on the blue write, with all three bytes, and the pointer then increments modulo 256.
- R4: Reads of port 1 return red, green and blue of the entry at the pointer. A read counter separate from the write counter is used, and the pointer increments after the blue read.
- R5: Port 2 reaches the control register chosen by the pointer: 0x04 read mask, 0x05 blink mask, 0x06 command, 0x07 test. Writes leave the pointer unchanged. Writes at any other pointer value are dropped, and reads there return 0x00.
- R6: When command bit 6 is 1, `{pixR,pixG,pixB}` one cycle after an index equals the colour-map entry at (index AND read mask), stored as {red, green, blue}.
- R7: When command bit 6 is 0, the pixel outputs are zero on the next cycle.
- R8: Port 3 writes change neither the colour map, the pointer nor either component sequence. Port 3 reads return 0x00.
- R9: A read is accepted only when `busWr` is low. `busRdata` changes only on the cycle after an accepted read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 2 | Port select: 0 pointer, 1 colour map, 2 control, 3 overlay |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe, one byte per cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after the read |
| pixIdx | input | 8 | Pixel index |
| pixR | output | 8 | Looked-up red |
| pixG | output | 8 | Looked-up green |
| pixB | output | 8 | Looked-up blue |

## Verification
Both results of the block are due one clock after their stimulus. Read data appears after the edge that samples an accepted read, and the looked-up colour appears after the edge that samples the index. A colour-map write becomes visible to a lookup or read issued on any later cycle. The driver records each expected byte or colour tagged with the cycle it is due. The monitor compares only on the falling edge of that cycle, so every comparison falls between the register updates and the next input change.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W = 3 * DATA_W;

  localparam logic [IDX_W-1:0] CTRL_RMASK = 8'h04;
  localparam logic [IDX_W-1:0] CTRL_BLINK = 8'h05;
  localparam logic [IDX_W-1:0] CTRL_CMD = 8'h06;
  localparam logic [IDX_W-1:0] CTRL_TEST = 8'h07;
  localparam int CMD_PAL_BIT = 6;

  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_CMAP = 2'd1,
    PORT_CTRL = 2'd2,
    PORT_OVLY = 2'd3
  } portSel_e;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  typedef struct packed {
    logic loadRed;
    logic loadGrn;
    logic commit;
    comp_e rdComp;
    logic [IDX_W-1:0] entryAddr;
    logic [IDX_W-1:0] pixMask;
    logic palOn;
  } dpStrobe_t;

  function automatic comp_e nextComp(comp_e c);
    case (c)
      COMP_RED: nextComp = COMP_GRN;
      COMP_GRN: nextComp = COMP_BLU;
      default: nextComp = COMP_RED;
    endcase
  endfunction
endpackage

// File: rtl/pdac_ctrl.sv
module pdac_ctrl
  import pdac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] busSel,
  input  logic busWr,
  input  logic busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] cmapByte,
  output logic [DATA_W-1:0] busRdata,
  output dpStrobe_t strb
);
  portSel_e portSel;
  logic [IDX_W-1:0] addrQ;
  comp_e wrPh;
  comp_e rdPh;
  logic [DATA_W-1:0] rmaskQ, blinkQ, cmdQ, testQ;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] ctrlRdVal;
  logic [DATA_W-1:0] rdMux;
  logic wrCmap, rdAccept;

  assign portSel = portSel_e'(busSel);
  assign wrCmap = busWr && (portSel == PORT_CMAP);
  assign rdAccept = busRd && !busWr;

  always_comb begin
    strb.loadRed = wrCmap && (wrPh == COMP_RED);
    strb.loadGrn = wrCmap && (wrPh == COMP_GRN);
    strb.commit = wrCmap && (wrPh == COMP_BLU);
    strb.rdComp = rdPh;
    strb.entryAddr = addrQ;
    strb.pixMask = rmaskQ;
    strb.palOn = cmdQ[CMD_PAL_BIT];
  end

  always_comb begin
    case (addrQ)
      CTRL_RMASK: ctrlRdVal = rmaskQ;
      CTRL_BLINK: ctrlRdVal = blinkQ;
      CTRL_CMD: ctrlRdVal = cmdQ;
      CTRL_TEST: ctrlRdVal = testQ;
      default: ctrlRdVal = '0;
    endcase
  end

  always_comb begin
    case (portSel)
      PORT_ADDR: rdMux = addrQ;
      PORT_CMAP: rdMux = cmapByte;
      PORT_CTRL: rdMux = ctrlRdVal;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      wrPh <= COMP_RED;
      rdPh <= COMP_RED;
      rmaskQ <= '1;
      blinkQ <= '0;
      cmdQ <= '0;
      testQ <= '0;
      rdataQ <= '0;
    end else if (busWr) begin
      case (portSel)
        PORT_ADDR: begin
          addrQ <= busWdata;
          wrPh <= COMP_RED;
          rdPh <= COMP_RED;
        end
        PORT_CMAP: begin
          wrPh <= nextComp(wrPh);
          if (wrPh == COMP_BLU) addrQ <= addrQ + 1'b1;
        end
        PORT_CTRL: begin
          case (addrQ)
            CTRL_RMASK: rmaskQ <= busWdata;
            CTRL_BLINK: blinkQ <= busWdata;
            CTRL_CMD: cmdQ <= busWdata;
            CTRL_TEST: testQ <= busWdata;
            default: ;
          endcase
        end
        default: ;
      endcase
    end else if (rdAccept) begin
      rdataQ <= rdMux;
      if (portSel == PORT_CMAP) begin
        rdPh <= nextComp(rdPh);
        if (rdPh == COMP_BLU) addrQ <= addrQ + 1'b1;
      end
    end
  end

  assign busRdata = rdataQ;
endmodule

// File: rtl/pdac_datapath.sv
module pdac_datapath
  import pdac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IDX_W-1:0] pixIdx,
  output logic [DATA_W-1:0] cmapByte,
  output logic [DATA_W-1:0] pixR,
  output logic [DATA_W-1:0] pixG,
  output logic [DATA_W-1:0] pixB
);
  logic [RGB_W-1:0] cmapMem [ENTRIES];
  logic [DATA_W-1:0] stageRed, stageGrn;
  logic [RGB_W-1:0] hostEntry;
  logic [RGB_W-1:0] pixEntry;
  logic [RGB_W-1:0] pixQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageRed <= '0;
      stageGrn <= '0;
    end else begin
      if (strb.loadRed) stageRed <= busWdata;
      if (strb.loadGrn) stageGrn <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) cmapMem[strb.entryAddr] <= {stageRed, stageGrn, busWdata};
  end

  assign hostEntry = cmapMem[strb.entryAddr];

  always_comb begin
    case (strb.rdComp)
      COMP_RED: cmapByte = hostEntry[3*DATA_W-1 -: DATA_W];
      COMP_GRN: cmapByte = hostEntry[2*DATA_W-1 -: DATA_W];
      default: cmapByte = hostEntry[DATA_W-1:0];
    endcase
  end

  assign pixEntry = cmapMem[pixIdx & strb.pixMask];

  always_ff @(posedge clk) begin
    if (!rstN) pixQ <= '0;
    else if (strb.palOn) pixQ <= pixEntry;
    else pixQ <= '0;
  end

  assign pixR = pixQ[3*DATA_W-1 -: DATA_W];
  assign pixG = pixQ[2*DATA_W-1 -: DATA_W];
  assign pixB = pixQ[DATA_W-1:0];
endmodule

// File: rtl/palette_dac_regs.sv
module palette_dac_regs
  import pdac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] busSel,
  input  logic busWr,
  input  logic busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic [7:0] pixIdx,
  output logic [7:0] pixR,
  output logic [7:0] pixG,
  output logic [7:0] pixB
);
  dpStrobe_t strb;
  logic [DATA_W-1:0] cmapByte;
  logic [IDX_W-1:0] curAddr;
  logic palOn;

  assign curAddr = strb.entryAddr;
  assign palOn = strb.palOn;

  pdac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .cmapByte(cmapByte), .busRdata(busRdata), .strb(strb)
  );

  pdac_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .pixIdx(pixIdx),
    .cmapByte(cmapByte), .pixR(pixR), .pixG(pixG), .pixB(pixB)
  );
endmodule

// File: rtl/pdac_checker.sv
module pdac_checker (
  input logic clk,
  input logic rstN,
  input logic [1:0] busSel,
  input logic busWr,
  input logic busRd,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic [7:0] pixR,
  input logic [7:0] pixG,
  input logic [7:0] pixB,
  input logic [7:0] curAddr,
  input logic palOn
);
  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd0) |=> (curAddr == $past(busWdata)));

  p_ctrl_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd2) |=> $stable(curAddr));

  p_palette_off_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !palOn |=> (pixR == 8'h00 && pixG == 8'h00 && pixB == 8'h00));

  p_overlay_no_effect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd3) |=> $stable(curAddr));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && !busWr) |=> $stable(busRdata));
endmodule

bind palette_dac_regs pdac_checker chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .pixR(pixR), .pixG(pixG),
  .pixB(pixB), .curAddr(curAddr), .palOn(palOn)
);

// File: tb/palette_dac_regs_tb_top.sv
module palette_dac_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] busSel;
  logic busWr, busRd;
  logic [7:0] busWdata, busRdata, pixIdx, pixR, pixG, pixB;

  always #(CLK_PERIOD / 2) clk = ~clk;

  palette_dac_regs dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pixIdx(pixIdx),
    .pixR(pixR), .pixG(pixG), .pixB(pixB)
  );

  typedef struct {
    int kind;
    logic [23:0] exp;
    int due;
    string req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  logic [23:0] mMap [256];
  logic [7:0] mAddr, mMask, mBlink, mCmd, mTest, mStR, mStG, mLastRd;
  int mWph, mRph;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      if (it.kind == 0) check(it.req, {16'h0, busRdata}, it.exp);
      else check(it.req, {pixR, pixG, pixB}, it.exp);
    end
  end

  function automatic logic [7:0] ctrlVal();
    case (mAddr)
      8'h04: return mMask;
      8'h05: return mBlink;
      8'h06: return mCmd;
      8'h07: return mTest;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    busSel = s; busWr = 1'b1; busRd = 1'b0; busWdata = d;
    case (s)
      2'd0: begin mAddr = d; mWph = 0; mRph = 0; end
      2'd1: begin
        if (mWph == 0) mStR = d;
        else if (mWph == 1) mStG = d;
        else begin mMap[mAddr] = {mStR, mStG, d}; mAddr = mAddr + 8'd1; end
        mWph = (mWph + 1) % 3;
      end
      2'd2: case (mAddr)
        8'h04: mMask = d;
        8'h05: mBlink = d;
        8'h06: mCmd = d;
        8'h07: mTest = d;
        default: ;
      endcase
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] s, string req);
    logic [7:0] e;
    @(negedge clk);
    busSel = s; busWr = 1'b0; busRd = 1'b1;
    case (s)
      2'd0: e = mAddr;
      2'd1: begin
        e = mMap[mAddr][23 - 8 * mRph -: 8];
        if (mRph == 2) mAddr = mAddr + 8'd1;
        mRph = (mRph + 1) % 3;
      end
      2'd2: e = ctrlVal();
      default: e = 8'h00;
    endcase
    mLastRd = e;
    sb.push_back('{0, {16'h0, e}, cyc + 1, req});
  endtask

  task automatic wrWithRd(logic [7:0] d, string req);
    wr(2'd0, d);
    busRd = 1'b1;
    sb.push_back('{0, {16'h0, mLastRd}, cyc + 1, req});
  endtask

  task automatic pix(logic [7:0] idx, string req);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; pixIdx = idx;
    sb.push_back('{1, mCmd[6] ? mMap[idx & mMask] : 24'h0, cyc + 1, req});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWr = 1'b0; busRd = 1'b0;
    end
  endtask

  task automatic loadEntry(logic [7:0] a, logic [23:0] c);
    wr(2'd0, a);
    wr(2'd1, c[23:16]); wr(2'd1, c[15:8]); wr(2'd1, c[7:0]);
  endtask

  initial begin
    rstN = 1'b0; busSel = 2'd0; busWr = 1'b0; busRd = 1'b0;
    busWdata = 8'h00; pixIdx = 8'h00;
    mAddr = 8'h00; mMask = 8'hFF; mBlink = 8'h00; mCmd = 8'h00; mTest = 8'h00;
    mStR = 8'h00; mStG = 8'h00; mLastRd = 8'h00; mWph = 0; mRph = 0;
    for (int i = 0; i < 256; i++) mMap[i] = 24'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata", {16'h0, busRdata}, 24'h0);
    check("R1 pixel", {pixR, pixG, pixB}, 24'h0);
    rd(2'd0, "R1 pointer");
    wr(2'd0, 8'h04); rd(2'd2, "R1 read mask");
    wr(2'd0, 8'h05); rd(2'd2, "R1 blink");
    wr(2'd0, 8'h06); rd(2'd2, "R1 command");
    wr(2'd0, 8'h07); rd(2'd2, "R1 test");

    // fill entries 0x00..0x02 and 0x10..0x11 in bursts (R3)
    wr(2'd0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      wr(2'd1, 8'h11 * i[7:0] + 8'h01); wr(2'd1, 8'hA0 + i[7:0]); wr(2'd1, 8'h5C ^ i[7:0]);
    end
    rd(2'd0, "R3 pointer after burst");
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hDE); wr(2'd1, 8'hAD); wr(2'd1, 8'hBE);
    wr(2'd1, 8'h12); wr(2'd1, 8'h34); wr(2'd1, 8'h56);
    rd(2'd0, "R3 pointer +2");

    // wrap at the top entry (R3)
    loadEntry(8'hFF, 24'hC0FFEE);
    rd(2'd0, "R3 pointer wrap");

    // read back (R4)
    wr(2'd0, 8'h10);
    for (int i = 0; i < 6; i++) rd(2'd1, "R4 cmap read");
    rd(2'd0, "R4 pointer after reads");
    wr(2'd0, 8'hFF);
    for (int i = 0; i < 3; i++) rd(2'd1, "R4 top entry");

    // pointer write mid-sequence restarts at red (R2)
    loadEntry(8'h20, 24'h0A0B0C);
    wr(2'd0, 8'h20); wr(2'd1, 8'h77); wr(2'd1, 8'h88);
    loadEntry(8'h21, 24'h313233);
    wr(2'd0, 8'h20);
    for (int i = 0; i < 6; i++) rd(2'd1, "R2 restart");

    // independent read and write counters sharing the pointer (R4)
    loadEntry(8'h30, 24'h102030);
    wr(2'd0, 8'h30); wr(2'd1, 8'h9A); wr(2'd1, 8'h9B);
    for (int i = 0; i < 3; i++) rd(2'd1, "R4 separate counters");
    wr(2'd1, 8'h9C);
    wr(2'd0, 8'h31);
    for (int i = 0; i < 3; i++) rd(2'd1, "R4 commit after read advance");

    // overlay port has no effect (R8)
    wr(2'd0, 8'h40); wr(2'd1, 8'h61); wr(2'd3, 8'h55); wr(2'd1, 8'h62);
    wr(2'd3, 8'hAA); wr(2'd1, 8'h63);
    rd(2'd0, "R8 pointer");
    rd(2'd3, "R8 overlay read");
    wr(2'd0, 8'h40);
    for (int i = 0; i < 3; i++) rd(2'd1, "R8 sequence intact");

    // palette disabled (R7)
    pix(8'h10, "R7 palette off");

    // control registers (R5)
    wr(2'd0, 8'h06); wr(2'd2, 8'h40);
    rd(2'd0, "R5 pointer unchanged");
    rd(2'd2, "R5 command readback");
    wr(2'd0, 8'h02); wr(2'd2, 8'h99);
    rd(2'd2, "R5 unmapped control");
    wr(2'd0, 8'h07); wr(2'd2, 8'h00); rd(2'd2, "R5 test");
    wr(2'd0, 8'h05); wr(2'd2, 8'h3C); rd(2'd2, "R5 blink");

    // lookups (R6)
    pix(8'h10, "R6 lookup 10");
    pix(8'h11, "R6 lookup 11");
    pix(8'h21, "R6 lookup 21");
    pix(8'hFF, "R6 lookup FF");
    wr(2'd0, 8'h04); wr(2'd2, 8'h0F);
    rd(2'd2, "R5 mask readback");
    pix(8'hF1, "R6 masked F1");
    pix(8'h22, "R6 masked 22");
    pix(8'h30, "R6 masked 30");

    // back to palette off (R7)
    wr(2'd0, 8'h06); wr(2'd2, 8'h00);
    pix(8'h01, "R7 palette off again");

    // read with write in same cycle is not accepted (R9)
    rd(2'd0, "R9 setup");
    wrWithRd(8'h5A, "R9 rdata held");
    idle(1);
    sb.push_back('{0, {16'h0, mLastRd}, cyc + 1, "R9 still held"});
    rd(2'd0, "R9 new pointer");

    idle(4);
    if (sb.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule